// File: doc/BRIEF.md
# Chained Serial Setup Loader

This block keeps a device's setup word in a single long shift register that is filled one bit at a time from a serial input. Each rising edge of the serial clock shifts in one bit while the serial enable is high. A bit counter tracks how many bits have entered since reset. When the last bit of the word has been taken in, the block stops shifting and freezes the word. It then pulls its active-low done output low. From that point on, it forwards its serial input combinationally to its serial output.

Several copies can be connected in a chain. Each device's serial output drives the next device's serial input, and the final device's serial output is left open. While a device is still loading, its serial output shows the bit at the tail of its register, so the stream keeps moving along the chain. Once the device is done, the rest of the stream reaches the next device directly.

The done state also gates the device's write-side queue selection. Until loading is finished, selection requests are refused. The loaded word is presented in parallel to the rest of the device.

The control is a three-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | Reset state; no bit has been taken yet. |
| `ST_LOAD` | At least one bit has been taken, but the word is not yet full. |
| `ST_PASS` | The word is full and the block passes serial data through. |

Its transitions are:

| Transition | Condition |
|---|---|
| `IDLE→LOAD` | First enabled edge, when the word is longer than one bit. |
| `IDLE→PASS` | First enabled edge, when the word is one bit long. |
| `LOAD→PASS` | The enabled edge that takes the last bit. |
| `PASS→PASS` | Held until reset. |
| any→`IDLE` | Reset. |

Top module: `cfg_loader`

## Requirements
- R1: While reset is asserted (rst_ni low), cfg_o is all zeros, done_no is 1, ser_o is 0 and sel_gnt_o is 0.
- R2: Before done, a rising clock edge with ser_en_i low changes neither cfg_o nor ser_o, whatever ser_i does.
- R3: Before done, a rising edge with ser_en_i high loads ser_i into cfg_o[CFG_BITS-1] and moves every bit k of cfg_o to position k-1, dropping bit 0.
- R4: Before done, ser_o equals cfg_o[0], the tail of the register.
- R5: done_no goes low right after the rising edge that takes the CFG_BITS-th enabled bit since reset, and stays low until the next reset.
- R6: After done, cfg_o keeps its value whatever ser_en_i and ser_i do.
- R7: After done, ser_o equals ser_i in the same cycle, with no clock delay.
- R8: sel_gnt_o is 0 while done_no is 1; after done, sel_gnt_o follows sel_req_i.
- R9: After a full load, cfg_o[0] holds the first bit shifted in and cfg_o[CFG_BITS-1] holds the last bit shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock; rising edge shifts |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_en_i | input | 1 | Shift enable, active high |
| ser_i | input | 1 | Serial data in |
| ser_o | output | 1 | Serial data out (register tail, or ser_i once done) |
| done_no | output | 1 | Load complete, active low |
| sel_req_i | input | 1 | Write-side queue selection request |
| sel_gnt_o | output | 1 | Request passed on only once loaded |
| cfg_o | output | CFG_BITS | Parallel view of the setup word |

## Verification
The bench builds the block with CFG_BITS set to 12. This keeps a full load short enough that the run can fill the word several times, with enable gaps at the start, in the middle and on the final bit. It also leaves room for a reset in the middle of a load, after which a second full load uses a different bit pattern. The short word lets every pass-through and frozen-word cycle after done be compared against the model along with the loading cycles.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PASS = 2'd2
    } ld_state_e;

endpackage

// File: rtl/cfg_bit_counter.sv
module cfg_bit_counter #(
    parameter int CFG_BITS = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = $clog2(CFG_BITS + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(CFG_BITS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != LAST_IDX)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign last_o = (cnt_q == LAST_IDX);

endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
    parameter int CFG_BITS = 64
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                shift_i,
    input  logic                din_i,
    output logic [CFG_BITS-1:0] word_o,
    output logic                tail_o
);
    logic [CFG_BITS-1:0] word_q;

    // Each stage takes its upper neighbour; the top stage takes the serial input.
    for (genvar i = 0; i < CFG_BITS; i++) begin : g_stage
        logic feed;
        if (i == CFG_BITS - 1) begin : g_head
            assign feed = din_i;
        end else begin : g_body
            assign feed = word_q[i+1];
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                word_q[i] <= 1'b0;
            end else if (shift_i) begin
                word_q[i] <= feed;
            end
        end
    end

    assign word_o = word_q;
    assign tail_o = word_q[0];

endmodule

// File: rtl/cfg_load_fsm.sv
module cfg_load_fsm
    import cfg_loader_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ser_en_i,
    input  logic last_i,
    output logic shift_o,
    output logic pass_o
);
    ld_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ser_en_i) begin
                    state_d = last_i ? ST_PASS : ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (ser_en_i && last_i) begin
                    state_d = ST_PASS;
                end
            end
            ST_PASS: begin
                state_d = ST_PASS;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        shift_o = 1'b0;
        pass_o  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_LOAD: begin
                shift_o = ser_en_i;
            end
            ST_PASS: begin
                pass_o = 1'b1;
            end
            default: begin
                shift_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
    parameter int CFG_BITS = 64
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                ser_en_i,
    input  logic                ser_i,
    output logic                ser_o,
    output logic                done_no,
    input  logic                sel_req_i,
    output logic                sel_gnt_o,
    output logic [CFG_BITS-1:0] cfg_o
);
    logic shift;
    logic pass;
    logic last;
    logic tail;

    cfg_load_fsm u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ser_en_i (ser_en_i),
        .last_i   (last),
        .shift_o  (shift),
        .pass_o   (pass)
    );

    cfg_bit_counter #(.CFG_BITS(CFG_BITS)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (shift),
        .last_o (last)
    );

    cfg_shift_reg #(.CFG_BITS(CFG_BITS)) u_sr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .shift_i (shift),
        .din_i   (ser_i),
        .word_o  (cfg_o),
        .tail_o  (tail)
    );

    assign ser_o     = pass ? ser_i : tail;
    assign done_no   = ~pass;
    assign sel_gnt_o = pass & sel_req_i;

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
    parameter int CFG_BITS = 64
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                ser_en_i,
    input logic                ser_i,
    input logic                ser_o,
    input logic                done_no,
    input logic                sel_req_i,
    input logic                sel_gnt_o,
    input logic [CFG_BITS-1:0] cfg_o
);
    int unsigned taken_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            taken_q <= 0;
        end else if (ser_en_i && done_no) begin
            taken_q <= taken_q + 1;
        end
    end

    AST_HOLD_NO_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ser_en_i && done_no) |=> ($stable(cfg_o) && $stable(ser_o))); // R2

    AST_SHIFT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ser_en_i && done_no) |=>
        (cfg_o == (($past(cfg_o) >> 1) | (CFG_BITS'($past(ser_i)) << (CFG_BITS - 1))))); // R3

    AST_TAIL_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_no |-> (ser_o == cfg_o[0])); // R4

    AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_no |=> !done_no); // R5

    AST_DONE_AT_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (taken_q == CFG_BITS) |-> !done_no); // R5

    AST_NOT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (taken_q < CFG_BITS) |-> done_no); // R5

    AST_FROZEN_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_no |=> $stable(cfg_o)); // R6

    AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_no |-> (ser_o == ser_i)); // R7

    AST_SEL_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_no |-> !sel_gnt_o); // R8

endmodule

bind cfg_loader cfg_loader_chk #(.CFG_BITS(CFG_BITS)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ser_en_i  (ser_en_i),
    .ser_i     (ser_i),
    .ser_o     (ser_o),
    .done_no   (done_no),
    .sel_req_i (sel_req_i),
    .sel_gnt_o (sel_gnt_o),
    .cfg_o     (cfg_o)
);

// File: tb/cfg_loader_test.sv
module cfg_loader_test;
    localparam int N = 12;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic         ser_en_i = 1'b0;
    logic         ser_i = 1'b0;
    logic         sel_req_i = 1'b0;
    logic         ser_o;
    logic         done_no;
    logic         sel_gnt_o;
    logic [N-1:0] cfg_o;

    int checks = 0;
    int fails  = 0;

    bit ref_q[$];
    bit ref_done = 0;
    bit first_bit;
    bit last_bit;

    cfg_loader #(.CFG_BITS(N)) uut (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ser_en_i  (ser_en_i),
        .ser_i     (ser_i),
        .ser_o     (ser_o),
        .done_no   (done_no),
        .sel_req_i (sel_req_i),
        .sel_gnt_o (sel_gnt_o),
        .cfg_o     (cfg_o)
    );

    always #10 clk_i = ~clk_i;

    function automatic logic [N-1:0] exp_cfg();
        logic [N-1:0] w = '0;
        int sz = ref_q.size();
        for (int j = 0; j < sz; j++) w[N - sz + j] = ref_q[j];
        return w;
    endfunction

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: compare registered outputs, drive inputs, compare
    // combinational outputs, then advance the model at the edge.
    task automatic step(input bit en, input bit din, input bit req);
        logic [N-1:0] w;
        @(negedge clk_i);
        w = exp_cfg();
        if (ref_done) chk("R6 word frozen", cfg_o, w);
        else          chk("R3 shifted word", cfg_o, w);
        chk("R5 done flag", N'(done_no), N'(!ref_done));
        ser_en_i  = en;
        ser_i     = din;
        sel_req_i = req;
        #1;
        if (ref_done) chk("R7 pass-through", N'(ser_o), N'(din));
        else          chk("R4 tail out", N'(ser_o), N'(w[0]));
        chk("R8 select gate", N'(sel_gnt_o), N'(req && ref_done));
        @(posedge clk_i);
        if (en && !ref_done) begin
            ref_q.push_back(din);
            if (ref_q.size() == N) ref_done = 1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        rst_ni = 1'b0;
        ser_i = 1'b1;
        ser_en_i = 1'b1;
        sel_req_i = 1'b1;
        #1;
        ref_q.delete();
        ref_done = 0;
        chk("R1 reset word", cfg_o, '0);
        chk("R1 reset done", N'(done_no), N'(1));
        chk("R1 reset ser_o", N'(ser_o), N'(0));
        chk("R1 reset grant", N'(sel_gnt_o), N'(0));
        @(negedge clk_i);
        ser_en_i = 1'b0;
        sel_req_i = 1'b0;
        rst_ni = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk_i);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R2: toggling data with enable low
        for (int i = 0; i < 4; i++) step(0, i[0], 1);
        // first part of the load, with gaps
        first_bit = 1;
        step(1, first_bit, 0);
        for (int i = 0; i < 4; i++) step(1, i[1], 1);
        for (int i = 0; i < 3; i++) step(0, 1, 0);
        for (int i = 0; i < N - 6; i++) step(1, (i % 3) == 0, 1);
        step(0, 0, 0);
        last_bit = 1;
        step(1, last_bit, 1);
        // R9 order of the loaded word
        @(negedge clk_i);
        chk("R9 first bit at 0", N'(cfg_o[0]), N'(first_bit));
        chk("R9 last bit at top", N'(cfg_o[N-1]), N'(last_bit));
        // after done: stream keeps going, word must hold
        for (int i = 0; i < 10; i++) step(i[0], i[1] ^ i[0], i[2]);
        // reset in the middle of a load
        do_reset();
        for (int i = 0; i < N / 2; i++) step(1, 1, 0);
        do_reset();
        for (int i = 0; i < N; i++) step(1, i[0], 1);
        for (int i = 0; i < 6; i++) step(1, i[1], i[0]);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule